// File: doc/BRIEF.md
# Synchronous SRAM Read Output Scheduler

This block is the read-data output stage of a synchronous burst SRAM. Each cycle the core hands it a command qualifier (read, write or deselect) and, one cycle after a read is captured, the word fetched from the array. The block decides in which cycle that word reaches the data bus and in which cycles the bus drivers are switched on. The aim is that reads, writes and deselects never fight over the bus.

Two static mode pins shape the schedule. The first selects pipelined output, which adds a rising-edge output register, or flow-through output, which bypasses it. The second selects the deselect behaviour. With single-cycle deselect, a deselect turns the drivers off one pipeline stage before a read would reach the bus. With dual-cycle deselect, a deselect travels as deep as a read, so the drivers stay on one full cycle longer. An asynchronous active-low output enable can switch the drivers off at any moment. A read issued while it is high is a dummy read: the read still occupies its slot, but the bus is never driven. A beat strobe marks every cycle in which a read occupies the output slot, so the latency in every mode can be checked automatically.

The mode pins are meant to be static and should only change while reset is held. Reset clears every stage to the deselected state with the drivers off.

Top module: `sram_out_sched`

## Requirements
- R1: While rst_ni is low, dq_oe_o, beat_o and dq_o are all 0.
- R2: With pipe_mode_i = 1 (pipelined), a read presented in cycle c raises beat_o in cycle c+2. In that cycle dq_o carries the rd_data_i value from cycle c+1.
- R3: With pipe_mode_i = 0 (flow-through), a read presented in cycle c raises beat_o in cycle c+1. In that cycle dq_o follows rd_data_i combinationally.
- R4: Four consecutive reads produce four beats in consecutive cycles, in issue order. The first beat comes 2 cycles after the read is presented when pipelined (3-1-1-1 counting the address cycle) and 1 cycle after when flow-through (2-1-1-1).
- R5: With dsel_single_i = 1 (single-cycle deselect), a deselect in cycle c forces dq_oe_o low in cycle c+1 when pipelined, and in cycle c itself when flow-through. This also cuts the beat of a read issued just before it.
- R6: With dsel_single_i = 0 (dual-cycle deselect), a deselect that follows a read does not cut that read's beat. The drivers turn off only in the cycle after that beat.
- R7: oe_ni = 1 drives dq_oe_o low at once, without waiting for a clock edge. oe_ni = 0 never enables the drivers in a cycle that holds no read beat.
- R8: In any cycle with cmd_wr_i = 1, dq_oe_o is 0. When cmd_rd_i and cmd_wr_i are both 1, the command is taken as a write and produces no beat.
- R9: A read issued with oe_ni = 1 for its beat cycle is a dummy read. It raises beat_o in its normal cycle, but dq_oe_o stays 0.
- R10: Whenever dq_oe_o is 0, dq_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = pipelined output, 0 = flow-through |
| dsel_single_i | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| cmd_rd_i | input | 1 | Read command this cycle |
| cmd_wr_i | input | 1 | Write command this cycle (wins over read) |
| rd_data_i | input | DATA_W | Array word for the read captured in the previous cycle |
| dq_o | output | DATA_W | Bus data, zero when not driven |
| dq_oe_o | output | 1 | Bus driver enable |
| beat_o | output | 1 | A read beat occupies the output slot this cycle |

## Verification
The bench builds the block with the default DATA_W of 72. Every rd_data_i word carries a distinct cycle-stamped pattern, so a beat that arrives one cycle early or late, or that takes a word meant for another read, shows up as a data mismatch. The pins select all four combinations of pipelined or flow-through output with single- or dual-cycle deselect, and the same command sequence runs under each. That sequence covers a read cut by a deselect, a deselect that holds the drivers one cycle longer, a write in a beat cycle, a dummy read, a combined read-and-write command, and an output-enable pulse in the middle of a cycle.

// File: rtl/sram_out_pkg.sv
package sram_out_pkg;
  typedef enum logic [1:0] {
    CMD_DSEL = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;

  // write wins over read when both are raised
  function automatic cmd_e decode_cmd(input logic rd, input logic wr);
    if (wr) return CMD_WR;
    if (rd) return CMD_RD;
    return CMD_DSEL;
  endfunction
endpackage

// File: rtl/sram_out_cmd_stage.sv
module sram_out_cmd_stage
  import sram_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  output cmd_e cmd_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q_o <= CMD_DSEL;
    else         cmd_q_o <= cmd_i;
  end
endmodule

// File: rtl/sram_out_data_stage.sv
module sram_out_data_stage
  import sram_out_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_q_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_q_o,
  output logic [DATA_W-1:0] data_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q_o   <= 1'b0;
      data_q_o <= '0;
    end else begin
      rd_q_o <= (cmd_q_i == CMD_RD);
      if (cmd_q_i == CMD_RD) data_q_o <= rd_data_i;
    end
  end
endmodule

// File: rtl/sram_out_drive_ctrl.sv
module sram_out_drive_ctrl
  import sram_out_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              pipe_mode_i,
  input  logic              dsel_single_i,
  input  logic              oe_ni,
  input  cmd_e              cmd_now_i,
  input  cmd_e              cmd_q_i,
  input  logic              rd_q_i,
  input  logic [DATA_W-1:0] data_q_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              beat_o
);
  logic              slot;
  logic              dsel_early;
  logic [DATA_W-1:0] slot_data;
  logic              drive;

  always_comb begin
    if (pipe_mode_i) begin
      slot       = rd_q_i;
      slot_data  = data_q_i;
      dsel_early = (cmd_q_i == CMD_DSEL);   // one stage short of the read
    end else begin
      slot       = (cmd_q_i == CMD_RD);
      slot_data  = rd_data_i;
      dsel_early = (cmd_now_i == CMD_DSEL);
    end
    drive = slot && !(dsel_single_i && dsel_early)
            && (cmd_now_i != CMD_WR) && !oe_ni;
  end

  assign beat_o  = slot;
  assign dq_oe_o = drive;
  assign dq_o    = drive ? slot_data : '0;
endmodule

// File: rtl/sram_out_sched.sv
module sram_out_sched
  import sram_out_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              dsel_single_i,
  input  logic              oe_ni,
  input  logic              cmd_rd_i,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              beat_o
);
  cmd_e              cmd_now;
  cmd_e              cmd_q;
  logic              rd_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_now = decode_cmd(cmd_rd_i, cmd_wr_i);

  sram_out_cmd_stage i_cmd_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_now),
    .cmd_q_o (cmd_q)
  );

  sram_out_data_stage #(.DATA_W(DATA_W)) i_data_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_q_i   (cmd_q),
    .rd_data_i (rd_data_i),
    .rd_q_o    (rd_q),
    .data_q_o  (data_q)
  );

  sram_out_drive_ctrl #(.DATA_W(DATA_W)) i_drive_ctrl (
    .pipe_mode_i   (pipe_mode_i),
    .dsel_single_i (dsel_single_i),
    .oe_ni         (oe_ni),
    .cmd_now_i     (cmd_now),
    .cmd_q_i       (cmd_q),
    .rd_q_i        (rd_q),
    .data_q_i      (data_q),
    .rd_data_i     (rd_data_i),
    .dq_o          (dq_o),
    .dq_oe_o       (dq_oe_o),
    .beat_o        (beat_o)
  );
endmodule

// File: rtl/sram_out_sched_chk.sv
module sram_out_sched_chk #(
  parameter int DATA_W = 72
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pipe_mode_i,
  input logic              dsel_single_i,
  input logic              oe_ni,
  input logic              cmd_rd_i,
  input logic              cmd_wr_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              beat_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!dq_oe_o && !beat_o && dq_o == '0);
  end

  // R2
  pipe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && cmd_rd_i && !cmd_wr_i) |-> ##2 beat_o);

  // R3
  flow_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && cmd_rd_i && !cmd_wr_i) |=> beat_o);

  // R5
  pipe_scd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && dsel_single_i && !cmd_rd_i && !cmd_wr_i) |=> !dq_oe_o);

  // R5
  flow_scd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && dsel_single_i && !cmd_rd_i && !cmd_wr_i) |-> !dq_oe_o);

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  // R7
  no_beat_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_o |-> !dq_oe_o);

  // R8
  write_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |-> !dq_oe_o);

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));
endmodule

bind sram_out_sched sram_out_sched_chk #(.DATA_W(DATA_W)) i_sram_out_sched_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pipe_mode_i   (pipe_mode_i),
  .dsel_single_i (dsel_single_i),
  .oe_ni         (oe_ni),
  .cmd_rd_i      (cmd_rd_i),
  .cmd_wr_i      (cmd_wr_i),
  .dq_o          (dq_o),
  .dq_oe_o       (dq_oe_o),
  .beat_o        (beat_o)
);

// File: tb/test_sram_out_sched.sv
module test_sram_out_sched;
  import sram_out_pkg::*;

  localparam int DW = 72;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pipe_mode_i = 1'b1;
  logic          dsel_single_i = 1'b1;
  logic          oe_ni = 1'b0;
  logic          cmd_rd_i = 1'b0;
  logic          cmd_wr_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;
  logic          beat_o;

  always #4 clk_i = ~clk_i;   // 125 MHz

  sram_out_sched #(.DATA_W(DW)) i_sram_out_sched (
    .clk_i, .rst_ni, .pipe_mode_i, .dsel_single_i, .oe_ni,
    .cmd_rd_i, .cmd_wr_i, .rd_data_i, .dq_o, .dq_oe_o, .beat_o
  );

  typedef struct {
    logic [DW-1:0] dq;
    logic          oe;
    logic          beat;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  int            checks = 0;
  int            fails = 0;
  bit            done = 0;
  cmd_e          h1 = CMD_DSEL, h2 = CMD_DSEL;
  logic [DW-1:0] d1 = '0;
  logic          prev_slot = 1'b0;
  int            cnt = 0;

  function automatic logic [DW-1:0] pat(input int n);
    logic [31:0] v;
    v = 32'(n);
    return {v[7:0] ^ 8'h3C, v ^ 32'hC3D2_E1F0, ~v};
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic do_reset(input logic pipe, input logic scd);
    @(negedge clk_i);
    rst_ni = 1'b0; cmd_rd_i = 1'b0; cmd_wr_i = 1'b0; oe_ni = 1'b0;
    pipe_mode_i = pipe; dsel_single_i = scd; rd_data_i = pat(999);
    @(negedge clk_i);
    #1;
    // R1
    check(!dq_oe_o && !beat_o && dq_o == '0, "R1",
          $sformatf("oe=%b beat=%b dq=%h expected 0 0 0", dq_oe_o, beat_o, dq_o));
    @(negedge clk_i);
    rst_ni = 1'b1;
    h1 = CMD_DSEL; h2 = CMD_DSEL; d1 = '0; prev_slot = 1'b0;
  endtask

  // one command cycle; expected outputs of this cycle go to the scoreboard
  task automatic cyc(input logic rd, input logic wr, input logic on, input bit pulse);
    cmd_e          h0;
    logic [DW-1:0] d0;
    logic          slot, early, en;
    exp_t          e;
    @(negedge clk_i);
    cnt++;
    d0 = pat(cnt);
    h0 = decode_cmd(rd, wr);
    cmd_rd_i = rd; cmd_wr_i = wr; oe_ni = on; rd_data_i = d0;
    slot  = pipe_mode_i ? (h2 == CMD_RD) : (h1 == CMD_RD);
    early = pipe_mode_i ? (h1 == CMD_DSEL) : (h0 == CMD_DSEL);
    en    = slot && !(dsel_single_i && early) && (h0 != CMD_WR) && !on;
    e.dq   = en ? (pipe_mode_i ? d1 : d0) : '0;
    e.oe   = en;
    e.beat = slot;
    if (slot && h0 == CMD_WR)                 e.tag = "R8";
    else if (slot && on)                      e.tag = "R9";
    else if (slot && dsel_single_i && early)  e.tag = "R5";
    else if (slot && early)                   e.tag = "R6";
    else if (slot && prev_slot)               e.tag = "R4";
    else if (slot)                            e.tag = pipe_mode_i ? "R2" : "R3";
    else                                      e.tag = "R10";
    exp_q.push_back(e);
    if (pulse && en) begin
      #1 oe_ni = 1'b1;
      #1;
      // R7: asynchronous disable mid-cycle
      check(!dq_oe_o && dq_o == '0, "R7",
            $sformatf("oe=%b dq=%h expected 0 0", dq_oe_o, dq_o));
      oe_ni = 1'b0;
    end
    h2 = h1; h1 = h0; d1 = d0; prev_slot = slot;
  endtask

  task automatic run_seq();
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 1); cyc(1, 0, 0, 0);   // R4 burst
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);   // R5/R6
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 0, 0, 0);   // R8
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);   // R9 dummy reads
    cyc(0, 0, 0, 0);
    cyc(1, 1, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);                    // R8 rd+wr
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
  endtask

  // scoreboard monitor: samples 1 ns before the next rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(dq_o === e.dq && dq_oe_o === e.oe && beat_o === e.beat, e.tag,
              $sformatf("dq=%h oe=%b beat=%b expected dq=%h oe=%b beat=%b",
                        dq_o, dq_oe_o, beat_o, e.dq, e.oe, e.beat));
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(logic'(m[1] == 1'b0), logic'(m[0] == 1'b0));
      run_seq();
      repeat (3) @(negedge clk_i);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule